// File: doc/BRIEF.md
# Dual-Channel DMA Control Register Block

This block holds the software-visible control state for two peripheral DMA channels: one channel feeding a SCSI-style disk controller and one feeding an Ethernet-style network controller. A 32-bit register bus selects one of eight 32-bit words by address. Writes land on a clock edge. Reads are combinational from the addressed word.

Each channel has a control/status word. That word always reads back a fixed version code in its top nibble. It also carries an interrupt-pending flag, an interrupt-enable flag, a peripheral-reset request and a transfer-direction bit. The SCSI channel also owns a current-address word. An external transfer-done strobe with a byte count stands in for the memory transfer itself. Each strobe advances the address word and marks an interrupt as pending. The Ethernet channel owns a base word, and the block ORs that base into every address the Ethernet peripheral presents. Peripheral reset requests leave the block as single-cycle pulses. There is one interrupt output for each channel.

Top module: `dma_csr_pair`

## Requirements
- R1: After reset, the SCSI control word (index 0) and the Ethernet control word (index 4) read 0xA0000000, and every other word reads 0. Both interrupt outputs and both reset pulses are low.
- R2: The word index is bus address bits [4:2]. Bits [1:0] and all bits above bit 4 have no effect on which word is read or written.
- R3: A write to index 1, 2, 3, 5, 6 or 7 stores the full 32-bit value, and it reads back unchanged on the next cycle.
- R4: A write to index 0 or index 4 stores 0xA in bits [31:28]. Bits [27:0] come from the written value, subject only to R5.
- R5: For index 0 only, bit 6 is the subject of two rules. When bit 7 (reset) of the written value is 0 and bit 6 is 1, bit 6 is stored as 0. When instead the written value is all zero, bit 6 is stored as 1.
- R6: A write to index 1 also sets bit 26 (loaded) of index 0. The other bits of index 0 keep their values.
- R7: A transfer-done strobe with byte count N adds N to index 1, modulo 2^32, and sets bit 0 (interrupt pending) of index 0. Both changes are readable on the next cycle.
- R8: A raise request sets bit 0 of index 0 and drives the SCSI interrupt high. A clear request resets bit 0 and drives the interrupt low. When both arrive in the same cycle, the clear wins.
- R9: A write to index 0 with bit 4 (interrupt enable) clear drives the SCSI interrupt low from the next cycle on.
- R10: The Ethernet interrupt output equals the Ethernet peripheral's interrupt level ANDed with bit 4 of index 4.
- R11: A write to index 0 with bit 7 set produces a SCSI peripheral reset pulse exactly one cycle long, in the cycle after the write. The same holds for index 4 and the Ethernet peripheral reset. Writes without bit 7 set produce no pulse.
- R12: The Ethernet bus address output equals the Ethernet peripheral's offset ORed with index 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register bus byte address |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed word (combinational) |
| xfer_done | input | 1 | SCSI transfer completed this cycle |
| xfer_len | input | 16 | Byte count of the completed transfer |
| scsi_irq_set | input | 1 | SCSI interrupt raise request |
| scsi_irq_clr | input | 1 | SCSI interrupt clear request |
| eth_irq_src | input | 1 | Interrupt level from the Ethernet peripheral |
| eth_offset | input | 32 | Address offset presented by the Ethernet peripheral |
| scsi_irq | output | 1 | SCSI channel interrupt |
| eth_irq | output | 1 | Ethernet channel interrupt |
| scsi_periph_rst | output | 1 | One-cycle reset pulse to the SCSI peripheral |
| eth_periph_rst | output | 1 | One-cycle reset pulse to the Ethernet peripheral |
| eth_bus_addr | output | 32 | Ethernet bus address, offset ORed with the base word |

## Verification
The block's results come due at different times after a stimulus:
- Stored words, the SCSI interrupt line and the reset pulses change at the first clock edge after a write or strobe. The bench drives every input on a falling edge and reads the result at the next falling edge, half a period after that clock edge.
- Each reset pulse is checked high at that falling edge and low one falling edge later, which confirms its one-cycle length.
- The Ethernet interrupt and the Ethernet bus address are combinational. Read data is also combinational from the address. The bench samples all of these one nanosecond after changing the address or offset, still before the next rising edge.

// File: rtl/dma_csr_pkg.sv
package dma_csr_pkg;
   // word indices whose roles are fixed by behaviour
   localparam int unsigned IDX_SCSI_CTL  = 0;
   localparam int unsigned IDX_SCSI_ADDR = 1;
   localparam int unsigned IDX_ETH_CTL   = 4;
   localparam int unsigned IDX_ETH_BASE  = 7;

   // control word bit positions
   localparam int unsigned PEND_B   = 0;
   localparam int unsigned IEN_B    = 4;
   localparam int unsigned ODD_B    = 6;
   localparam int unsigned RST_B    = 7;
   localparam int unsigned DIR_B    = 8;
   localparam int unsigned LOADED_B = 26;

   localparam int unsigned VER_W    = 4;
endpackage

// File: rtl/dma_ctl_word.sv
module dma_ctl_word
   import dma_csr_pkg::*;
#(
   parameter int unsigned       DW       = 32,
   parameter logic [VER_W-1:0]  VER      = 4'hA,
   parameter bit                ODD_RULE = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   input  logic          set_loaded,
   input  logic          set_pend,
   input  logic          clr_pend,
   output logic [DW-1:0] ctl_q,
   output logic          rst_pulse
);
   localparam logic [DW-1:0] RESET_WORD = {VER, {(DW-VER_W){1'b0}}};

   logic [DW-1:0] shaped;

   generate
      if (ODD_RULE) begin : g_odd
         always_comb begin
            shaped = wdata;
            if (!wdata[RST_B]) begin
               if (wdata[ODD_B])
                  shaped[ODD_B] = 1'b0;
               else if (wdata == '0)
                  shaped[ODD_B] = 1'b1;
            end
         end
      end else begin : g_plain
         assign shaped = wdata;
      end
   endgenerate

   logic [DW-1:0] stamped;
   assign stamped = {VER, shaped[DW-VER_W-1:0]};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q     <= RESET_WORD;
         rst_pulse <= 1'b0;
      end else begin
         rst_pulse <= wr_en & wdata[RST_B];
         if (wr_en) begin
            ctl_q <= stamped;
         end else begin
            if (set_loaded)
               ctl_q[LOADED_B] <= 1'b1;
            if (clr_pend)
               ctl_q[PEND_B] <= 1'b0;
            else if (set_pend)
               ctl_q[PEND_B] <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/dma_addr_ctr.sv
module dma_addr_ctr #(
   parameter int unsigned DW    = 32,
   parameter int unsigned LEN_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [DW-1:0]    wdata,
   input  logic             adv,
   input  logic [LEN_W-1:0] adv_len,
   output logic [DW-1:0]    q
);
   localparam int unsigned PAD_W = DW - LEN_W;

   logic [DW-1:0] step;

   generate
      if (PAD_W > 0) begin : g_pad
         assign step = {{PAD_W{1'b0}}, adv_len};
      end else begin : g_full
         assign step = adv_len[DW-1:0];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (wr_en)
         q <= wdata;
      else if (adv)
         q <= q + step;
   end
endmodule

// File: rtl/dma_plain_reg.sv
module dma_plain_reg #(
   parameter int unsigned DW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [DW-1:0] wdata,
   output logic [DW-1:0] q
);
   always_ff @(posedge clk) begin
      if (!rst_n)
         q <= '0;
      else if (wr_en)
         q <= wdata;
   end
endmodule

// File: rtl/dma_csr_pair.sv
module dma_csr_pair
   import dma_csr_pkg::*;
#(
   parameter int unsigned      DW     = 32,
   parameter int unsigned      NREGS  = 8,
   parameter int unsigned      ADDR_W = 8,
   parameter int unsigned      LEN_W  = 16,
   parameter logic [VER_W-1:0] VER    = 4'hA
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DW-1:0]     bus_wdata,
   output logic [DW-1:0]     bus_rdata,
   input  logic              xfer_done,
   input  logic [LEN_W-1:0]  xfer_len,
   input  logic              scsi_irq_set,
   input  logic              scsi_irq_clr,
   input  logic              eth_irq_src,
   input  logic [DW-1:0]     eth_offset,
   output logic              scsi_irq,
   output logic              eth_irq,
   output logic              scsi_periph_rst,
   output logic              eth_periph_rst,
   output logic [DW-1:0]     eth_bus_addr
);
   localparam int unsigned IDX_W = $clog2(NREGS);
   localparam int unsigned IDX_LO = 2;
   localparam int unsigned IDX_HI = IDX_LO + IDX_W - 1;

   generate
      if (DW != 32) begin : g_bad_dw
         $error("dma_csr_pair: DW must be 32");
      end
      if (NREGS != 8) begin : g_bad_nregs
         $error("dma_csr_pair: NREGS must be 8");
      end
      if (ADDR_W < IDX_HI + 2) begin : g_bad_aw
         $error("dma_csr_pair: ADDR_W too small for the index field");
      end
      if (LEN_W > DW || LEN_W == 0) begin : g_bad_len
         $error("dma_csr_pair: LEN_W out of range");
      end
   endgenerate

   // word select; only bits [IDX_HI:IDX_LO] matter
   logic [IDX_W-1:0] idx;
   assign idx = bus_addr[IDX_HI:IDX_LO];

   logic unused_addr_bits;
   assign unused_addr_bits = ^{bus_addr[ADDR_W-1:IDX_HI+1], bus_addr[IDX_LO-1:0]};

   logic [NREGS-1:0] wr_sel;
   always_comb begin
      wr_sel = '0;
      if (bus_wr)
         wr_sel[idx] = 1'b1;
   end

   logic [DW-1:0] scsi_ctl_q;
   logic [DW-1:0] eth_ctl_q;
   logic [DW-1:0] regs_q [NREGS];

   dma_ctl_word #(.DW(DW), .VER(VER), .ODD_RULE(1'b1)) scsi_ctl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_sel[IDX_SCSI_CTL]),
      .wdata      (bus_wdata),
      .set_loaded (wr_sel[IDX_SCSI_ADDR]),
      .set_pend   (xfer_done | scsi_irq_set),
      .clr_pend   (scsi_irq_clr),
      .ctl_q      (scsi_ctl_q),
      .rst_pulse  (scsi_periph_rst)
   );

   dma_ctl_word #(.DW(DW), .VER(VER), .ODD_RULE(1'b0)) eth_ctl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_sel[IDX_ETH_CTL]),
      .wdata      (bus_wdata),
      .set_loaded (1'b0),
      .set_pend   (1'b0),
      .clr_pend   (1'b0),
      .ctl_q      (eth_ctl_q),
      .rst_pulse  (eth_periph_rst)
   );

   generate
      for (genvar g = 0; g < NREGS; g++) begin : g_word
         if (g == IDX_SCSI_CTL) begin : g_sctl
            assign regs_q[g] = scsi_ctl_q;
         end else if (g == IDX_ETH_CTL) begin : g_ectl
            assign regs_q[g] = eth_ctl_q;
         end else if (g == IDX_SCSI_ADDR) begin : g_saddr
            dma_addr_ctr #(.DW(DW), .LEN_W(LEN_W)) addr_i (
               .clk     (clk),
               .rst_n   (rst_n),
               .wr_en   (wr_sel[g]),
               .wdata   (bus_wdata),
               .adv     (xfer_done),
               .adv_len (xfer_len),
               .q       (regs_q[g])
            );
         end else begin : g_store
            dma_plain_reg #(.DW(DW)) word_i (
               .clk   (clk),
               .rst_n (rst_n),
               .wr_en (wr_sel[g]),
               .wdata (bus_wdata),
               .q     (regs_q[g])
            );
         end
      end
   endgenerate

   assign bus_rdata = regs_q[idx];

   // SCSI interrupt line: a disabling write wins, then clear, then raise
   logic scsi_irq_q;
   always_ff @(posedge clk) begin
      if (!rst_n)
         scsi_irq_q <= 1'b0;
      else if (wr_sel[IDX_SCSI_CTL] && !bus_wdata[IEN_B])
         scsi_irq_q <= 1'b0;
      else if (scsi_irq_clr)
         scsi_irq_q <= 1'b0;
      else if (scsi_irq_set)
         scsi_irq_q <= 1'b1;
   end
   assign scsi_irq = scsi_irq_q;

   assign eth_irq      = eth_irq_src & eth_ctl_q[IEN_B];
   assign eth_bus_addr = eth_offset | regs_q[IDX_ETH_BASE];
endmodule

// File: rtl/dma_csr_pair_chk.sv
module dma_csr_pair_chk #(
   parameter int unsigned DW     = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned LEN_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DW-1:0]     bus_wdata,
   input logic              xfer_done,
   input logic [LEN_W-1:0]  xfer_len,
   input logic              scsi_irq_clr,
   input logic              scsi_irq,
   input logic              scsi_periph_rst,
   input logic              eth_periph_rst,
   input logic [DW-1:0]     ctl0,
   input logic [DW-1:0]     ctl4,
   input logic [DW-1:0]     addr1
);
   logic wr0, wr1, wr4;
   assign wr0 = bus_wr && (bus_addr[4:2] == 3'd0);
   assign wr1 = bus_wr && (bus_addr[4:2] == 3'd1);
   assign wr4 = bus_wr && (bus_addr[4:2] == 3'd4);

   // R4
   ver_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctl0[31:28] == 4'hA) && (ctl4[31:28] == 4'hA));

   // R6
   loaded_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr1 |=> ctl0[26]);

   // R7
   addr_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (xfer_done && !wr1) |=> (addr1 == $past(addr1) + DW'($past(xfer_len))));

   // R8
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (scsi_irq_clr && !wr0) |=> (!scsi_irq && !ctl0[0]));

   // R9
   irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && !bus_wdata[4]) |=> !scsi_irq);

   // R11
   scsi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr0 && bus_wdata[7]) |=> scsi_periph_rst);

   // R11
   scsi_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr0 && bus_wdata[7]) |=> !scsi_periph_rst);

   // R11
   eth_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr4 && bus_wdata[7]) |=> eth_periph_rst);

   // R11
   eth_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr4 && bus_wdata[7]) |=> !eth_periph_rst);
endmodule

bind dma_csr_pair dma_csr_pair_chk #(.DW(DW), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) chk_i (
   .clk             (clk),
   .rst_n           (rst_n),
   .bus_addr        (bus_addr),
   .bus_wr          (bus_wr),
   .bus_wdata       (bus_wdata),
   .xfer_done       (xfer_done),
   .xfer_len        (xfer_len),
   .scsi_irq_clr    (scsi_irq_clr),
   .scsi_irq        (scsi_irq),
   .scsi_periph_rst (scsi_periph_rst),
   .eth_periph_rst  (eth_periph_rst),
   .ctl0            (scsi_ctl_q),
   .ctl4            (eth_ctl_q),
   .addr1           (regs_q[1])
);

// File: tb/dma_csr_pair_tb_top.sv
`timescale 1ns/100ps
module dma_csr_pair_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        xfer_done = 1'b0;
   logic [15:0] xfer_len = '0;
   logic        scsi_irq_set = 1'b0;
   logic        scsi_irq_clr = 1'b0;
   logic        eth_irq_src = 1'b0;
   logic [31:0] eth_offset = 32'h0000_0C35;
   logic        scsi_irq, eth_irq, scsi_periph_rst, eth_periph_rst;
   logic [31:0] eth_bus_addr;

   int n_chk = 0;
   int n_err = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   dma_csr_pair dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_done(xfer_done),
      .xfer_len(xfer_len), .scsi_irq_set(scsi_irq_set), .scsi_irq_clr(scsi_irq_clr),
      .eth_irq_src(eth_irq_src), .eth_offset(eth_offset), .scsi_irq(scsi_irq),
      .eth_irq(eth_irq), .scsi_periph_rst(scsi_periph_rst),
      .eth_periph_rst(eth_periph_rst), .eth_bus_addr(eth_bus_addr)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1;
      d = bus_rdata;
   endtask

   task automatic pulse_in(input bit raise, input bit clear);
      @(negedge clk);
      scsi_irq_set = raise; scsi_irq_clr = clear;
      @(negedge clk);
      scsi_irq_set = 1'b0; scsi_irq_clr = 1'b0;
   endtask

   function automatic logic [31:0] exp_ctl0(input logic [31:0] v);
      logic [31:0] t = v;
      if (!v[7] && v[6]) t[6] = 1'b0;
      else if (v == 32'h0) t[6] = 1'b1;
      return {4'hA, t[27:0]};
   endfunction

   initial begin
      #(4 * 150000);
      if (!finished) begin
         n_err++; n_chk++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [31:0] cur;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int i = 0; i < 8; i++) begin
         rd(8'(i * 4), d);
         chk("R1 reset word", d, (i == 0 || i == 4) ? 32'hA000_0000 : 32'h0);
      end
      chk("R1 scsi_irq", {31'h0, scsi_irq}, 32'h0);
      chk("R1 eth_irq", {31'h0, eth_irq}, 32'h0);
      chk("R1 pulses", {30'h0, scsi_periph_rst, eth_periph_rst}, 32'h0);
      chk("R12 base zero", eth_bus_addr, eth_offset);

      // R2 R3 R12: plain words through aliased addresses
      for (int k = 0; k < 5; k++) begin
         int ix;
         ix = (k == 0) ? 2 : (k == 1) ? 3 : (k == 2) ? 5 : (k == 3) ? 6 : 7;
         for (int hl = 0; hl < 32; hl++) begin
            logic [7:0] a;
            logic [31:0] v;
            a = {hl[4:2], 3'(ix), hl[1:0]};
            v = 32'h1357_0000 ^ ({24'h0, a} * 32'h0101_0101);
            wr(a, v);
            rd(a ^ 8'hE3, d);
            chk("R2 R3 alias readback", d, v);
            if (ix == 7) begin
               eth_offset = 32'h8000_0001 ^ {24'h0, a};
               #1;
               chk("R12 eth_bus_addr", eth_bus_addr, eth_offset | v);
            end
         end
      end

      // R4 R5 R9 R11: sweep of SCSI control writes
      for (int i = 0; i < 32; i++) begin
         logic [31:0] v;
         v = {i[4] ? 32'h5000_0100 : 32'h0} | {31'h0, i[0]} | (i[1] ? 32'h10 : 32'h0)
           | (i[2] ? 32'h40 : 32'h0) | (i[3] ? 32'h80 : 32'h0);
         pulse_in(1'b1, 1'b0);
         wr(8'h00, v);
         chk("R11 scsi pulse", {31'h0, scsi_periph_rst}, {31'h0, v[7]});
         chk("R9 scsi_irq after write", {31'h0, scsi_irq}, {31'h0, v[4]});
         rd(8'h00, d);
         chk("R4 R5 ctl0 store", d, exp_ctl0(v));
         @(negedge clk);
         chk("R11 scsi pulse one cycle", {31'h0, scsi_periph_rst}, 32'h0);
      end

      // R4 R10 R11: sweep of Ethernet control writes
      eth_irq_src = 1'b1;
      for (int i = 0; i < 32; i++) begin
         logic [31:0] v;
         v = {i[4] ? 32'h5000_0100 : 32'h0} | {31'h0, i[0]} | (i[1] ? 32'h10 : 32'h0)
           | (i[2] ? 32'h40 : 32'h0) | (i[3] ? 32'h80 : 32'h0);
         wr(8'h10, v);
         chk("R11 eth pulse", {31'h0, eth_periph_rst}, {31'h0, v[7]});
         chk("R10 eth_irq", {31'h0, eth_irq}, {31'h0, v[4]});
         rd(8'h10, d);
         chk("R4 ctl4 store", d, {4'hA, v[27:0]});
         @(negedge clk);
         chk("R11 eth pulse one cycle", {31'h0, eth_periph_rst}, 32'h0);
      end
      eth_irq_src = 1'b0;
      #1;
      chk("R10 eth_irq source low", {31'h0, eth_irq}, 32'h0);

      // R6 R7: address load and advance
      wr(8'h00, 32'h0000_0010);
      rd(8'h00, d);
      chk("R5 ctl0 plain", d, 32'hA000_0010);
      cur = 32'hFFFF_FFF0;
      wr(8'h04, cur);
      rd(8'h00, d);
      chk("R6 loaded bit", d, 32'hA400_0010);
      rd(8'h04, d);
      chk("R6 addr stored", d, cur);
      for (int j = 0; j < 4; j++) begin
         logic [15:0] l;
         l = (j == 0) ? 16'h0020 : (j == 1) ? 16'h0001 : (j == 2) ? 16'h0003 : 16'hFFFF;
         @(negedge clk);
         xfer_done = 1'b1; xfer_len = l;
         @(negedge clk);
         xfer_done = 1'b0;
         cur = cur + {16'h0, l};
         rd(8'h04, d);
         chk("R7 addr advance", d, cur);
         rd(8'h00, d);
         chk("R7 pending set", d, 32'hA400_0011);
      end

      // R8 raise / clear / collision
      wr(8'h00, 32'h0000_0010);
      pulse_in(1'b1, 1'b0);
      rd(8'h00, d);
      chk("R8 raise bit0", d, 32'hA000_0011);
      chk("R8 raise line", {31'h0, scsi_irq}, 32'h1);
      pulse_in(1'b0, 1'b1);
      rd(8'h00, d);
      chk("R8 clear bit0", d, 32'hA000_0010);
      chk("R8 clear line", {31'h0, scsi_irq}, 32'h0);
      pulse_in(1'b1, 1'b0);
      pulse_in(1'b1, 1'b1);
      rd(8'h00, d);
      chk("R8 clear wins bit0", d, 32'hA000_0010);
      chk("R8 clear wins line", {31'h0, scsi_irq}, 32'h0);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule